// File: doc/BRIEF.md
# Paired Atomic Compare-and-Swap Unit

This unit executes one paired compare-and-swap against a small internal memory. The request comes already decoded. It carries a size select, two compare register values, two swap register values, the register numbers of the compare and swap pairs, a byte address, a flag that marks the address as taken from the stack pointer, and an endianness flag.

The unit reads the paired location and joins the two compare registers into one double-width value. It compares that value with memory. On an exact match it writes the joined swap value back. In every case it returns the old memory contents, split back into two destination register values. The order in which the two registers are joined and split depends on the endianness flag.

A second memory port serves other agents. It is refused while an operation is in flight, so nothing can modify the location between the read and the conditional write. Requests with odd register numbers or a misaligned address are rejected with a fault. A faulted request makes no memory access, and the original compare values come back unchanged.

Top module: `casp_pair_unit`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid_i` is high and `busy_o` is low. After that edge, `req_ack_o` is high for exactly one cycle. `busy_o` stays high until the edge that raises `rsp_valid_o`. `rsp_valid_o` rises on the second edge after acceptance and lasts one cycle.
- R2: With `req_size_i`=1, the memory value is 128 bits: the doubleword at the 16-byte-aligned address is the low half and the next doubleword is the high half. The compare value is {a,b} when `req_big_endian_i`=1 and {b,a} when it is 0.
- R3: With `req_size_i`=0, only the low 32 bits of each register take part. The memory value is the 64-bit doubleword at the address. The compare value is {a[31:0],b[31:0]} for big-endian and {b[31:0],a[31:0]} for little-endian.
- R4: When the memory value equals the compare value, the swap pair is written. It is joined in the same order as the compare pair. `rsp_swapped_o` is then 1.
- R5: When the values differ, memory is left unchanged and `rsp_swapped_o` is 0.
- R6: On a non-faulting request, the old memory value is returned. For big-endian, the upper half goes to `rsp_old_a_o` and the lower half to `rsp_old_b_o`. For little-endian, the lower half goes to `rsp_old_a_o` and the upper half to `rsp_old_b_o`. For size 0, each half is 32 bits and is zero-extended. `rsp_wb_o` is 1.
- R7: An odd `req_cmp_reg_i` or an odd `req_swap_reg_i` sets `rsp_illegal_o`.
- R8: When the address is not from the stack pointer, it must be aligned to 8 bytes for size 0 and to 16 bytes for size 1. Otherwise `rsp_align_fault_o` is set.
- R9: An address taken from the stack pointer must be 16-byte aligned for either size. Otherwise `rsp_align_fault_o` is set.
- R10: A faulting request makes no memory access and clears `rsp_wb_o` and `rsp_swapped_o`. It returns the original compare values unchanged in `rsp_old_a_o` and `rsp_old_b_o`.
- R11: `excl_clr_o` pulses for one cycle, in the cycle before `rsp_valid_o`, for every non-faulting request, including a failed compare. A faulting request gives no pulse.
- R12: The external port addresses doublewords and returns read data one cycle after acceptance, with `ext_rvalid_o`. It is accepted only while `ext_ready_o` is high. `ext_ready_o` is low while `busy_o` is high. A write offered while the port is stalled is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request offered |
| req_size_i | input | 1 | 0: 32-bit registers, 1: 64-bit registers |
| req_big_endian_i | input | 1 | Big-endian pair ordering |
| req_sp_base_i | input | 1 | Address comes from the stack pointer |
| req_cmp_reg_i | input | 5 | Register number of the compare pair |
| req_swap_reg_i | input | 5 | Register number of the swap pair |
| req_addr_i | input | ADDR_W | Byte address |
| req_cmp_a_i | input | DW | First compare register |
| req_cmp_b_i | input | DW | Second compare register |
| req_new_a_i | input | DW | First swap register |
| req_new_b_i | input | DW | Second swap register |
| req_ack_o | output | 1 | One-cycle acceptance pulse |
| busy_o | output | 1 | Operation in flight |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_wb_o | output | 1 | Destination registers to be written |
| rsp_swapped_o | output | 1 | Compare matched and memory was written |
| rsp_align_fault_o | output | 1 | Alignment fault |
| rsp_illegal_o | output | 1 | Odd register number |
| rsp_old_a_o | output | DW | Value for the first compare register |
| rsp_old_b_o | output | DW | Value for the second compare register |
| excl_clr_o | output | 1 | Exclusive-monitor clear pulse |
| ext_en_i | input | 1 | External access request |
| ext_we_i | input | 1 | External write |
| ext_addr_i | input | ADDR_W-3 | External doubleword index |
| ext_wdata_i | input | DW | External write data |
| ext_ready_o | output | 1 | External port not stalled |
| ext_rvalid_o | output | 1 | External read data valid |
| ext_rdata_o | output | DW | External read data |

## Verification
Each operation is sampled on falling edges, counted from the accepting edge. The acknowledge and busy state are checked one edge later. The exclusive clear pulse is checked two edges after acceptance, and the result three edges after. Every expected result carries the cycle count at which it is due, and the monitor compares that count with the cycle in which `rsp_valid_o` is actually seen. External reads are checked one edge after the read is accepted. Memory contents after swaps, mismatches, faults and stalled writes are checked through the external port against a model in the bench.

// File: rtl/casp_pkg.sv
package casp_pkg;
  localparam int REGNUM_W    = 5;
  localparam int SP_ALIGN_LG = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_CMP   = 2'd2
  } casp_state_e;
endpackage

// File: rtl/casp_bank.sv
module casp_bank #(
  parameter int AW = 5,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int ROWS = 2 ** AW;

  logic [DW-1:0] mem [ROWS];

  // single port, read-before-write, registered output
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/casp_pack.sv
module casp_pack #(
  parameter int DW = 64
) (
  input  logic            size,
  input  logic            big_endian,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [2*DW-1:0] pair
);
  localparam int HW = DW / 2;

  always_comb begin
    if (size)
      pair = big_endian ? {a, b} : {b, a};
    else if (big_endian)
      pair = {{DW{1'b0}}, a[HW-1:0], b[HW-1:0]};
    else
      pair = {{DW{1'b0}}, b[HW-1:0], a[HW-1:0]};
  end
endmodule

// File: rtl/casp_unpack.sv
module casp_unpack #(
  parameter int DW = 64
) (
  input  logic            size,
  input  logic            big_endian,
  input  logic [2*DW-1:0] pair,
  output logic [DW-1:0]   a,
  output logic [DW-1:0]   b
);
  localparam int HW = DW / 2;

  logic [DW-1:0] upper_w, lower_w;

  always_comb begin
    if (size) begin
      upper_w = pair[2*DW-1:DW];
      lower_w = pair[DW-1:0];
    end else begin
      upper_w = {{HW{1'b0}}, pair[DW-1:HW]};
      lower_w = {{HW{1'b0}}, pair[HW-1:0]};
    end
    a = big_endian ? upper_w : lower_w;
    b = big_endian ? lower_w : upper_w;
  end
endmodule

// File: rtl/casp_fault.sv
module casp_fault #(
  parameter int LOW_W = 4,
  parameter int LG_S0 = 3,
  parameter int LG_S1 = 4,
  parameter int LG_SP = 4
) (
  input  logic                         size,
  input  logic                         sp_base,
  input  logic [LOW_W-1:0]             addr_lo,
  input  logic [casp_pkg::REGNUM_W-1:0] cmp_reg,
  input  logic [casp_pkg::REGNUM_W-1:0] swap_reg,
  output logic                         align_fault,
  output logic                         illegal
);
  localparam int RW = casp_pkg::REGNUM_W;
  localparam logic [LOW_W-1:0] MASK_S0 = LOW_W'((1 << LG_S0) - 1);
  localparam logic [LOW_W-1:0] MASK_S1 = LOW_W'((1 << LG_S1) - 1);
  localparam logic [LOW_W-1:0] MASK_SP = LOW_W'((1 << LG_SP) - 1);

  logic [LOW_W-1:0] mask_w;

  always_comb begin
    if (sp_base)   mask_w = MASK_SP;
    else if (size) mask_w = MASK_S1;
    else           mask_w = MASK_S0;
    align_fault = (addr_lo & mask_w) != '0;
    illegal     = ((cmp_reg & RW'(1)) != '0) || ((swap_reg & RW'(1)) != '0);
  end
endmodule

// File: rtl/casp_pair_unit.sv
module casp_pair_unit #(
  parameter int ADDR_W = 9,
  parameter int DW     = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid_i,
  input  logic                          req_size_i,
  input  logic                          req_big_endian_i,
  input  logic                          req_sp_base_i,
  input  logic [casp_pkg::REGNUM_W-1:0] req_cmp_reg_i,
  input  logic [casp_pkg::REGNUM_W-1:0] req_swap_reg_i,
  input  logic [ADDR_W-1:0]             req_addr_i,
  input  logic [DW-1:0]                 req_cmp_a_i,
  input  logic [DW-1:0]                 req_cmp_b_i,
  input  logic [DW-1:0]                 req_new_a_i,
  input  logic [DW-1:0]                 req_new_b_i,
  output logic                          req_ack_o,
  output logic                          busy_o,
  output logic                          rsp_valid_o,
  output logic                          rsp_wb_o,
  output logic                          rsp_swapped_o,
  output logic                          rsp_align_fault_o,
  output logic                          rsp_illegal_o,
  output logic [DW-1:0]                 rsp_old_a_o,
  output logic [DW-1:0]                 rsp_old_b_o,
  output logic                          excl_clr_o,
  input  logic                          ext_en_i,
  input  logic                          ext_we_i,
  input  logic [ADDR_W-4:0]             ext_addr_i,
  input  logic [DW-1:0]                 ext_wdata_i,
  output logic                          ext_ready_o,
  output logic                          ext_rvalid_o,
  output logic [DW-1:0]                 ext_rdata_o
);
  import casp_pkg::*;

  localparam int LOW_W  = $clog2(DW / 4);
  localparam int ROW_AW = ADDR_W - LOW_W;
  localparam int NBANK  = 2;

  casp_state_e state_q;
  logic                busy_q;
  logic                sz_q, be_q, sp_q;
  logic [REGNUM_W-1:0] creg_q, sreg_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DW-1:0]       ca_q, cb_q, na_q, nb_q;

  logic            align_flt, ill_flt, fault_any;
  logic [2*DW-1:0] cmp_val, new_val, old_val;
  logic [DW-1:0]   old_a, old_b;
  logic            match, do_write, ext_go, ext_bank_q;
  logic [ROW_AW-1:0] row_w;
  logic              hi_w;

  logic [NBANK-1:0]  bank_en, bank_we;
  logic [ROW_AW-1:0] bank_addr [NBANK];
  logic [DW-1:0]     bank_wd   [NBANK];
  logic [DW-1:0]     bank_q    [NBANK];

  assign row_w = addr_q[ADDR_W-1:LOW_W];
  assign hi_w  = addr_q[LOW_W-1];

  casp_fault #(
    .LOW_W(LOW_W), .LG_S0($clog2(DW / 8)), .LG_S1(LOW_W), .LG_SP(SP_ALIGN_LG)
  ) u_fault (
    .size(sz_q), .sp_base(sp_q), .addr_lo(addr_q[LOW_W-1:0]),
    .cmp_reg(creg_q), .swap_reg(sreg_q),
    .align_fault(align_flt), .illegal(ill_flt)
  );
  assign fault_any = align_flt | ill_flt;

  casp_pack #(.DW(DW)) u_pack_cmp (
    .size(sz_q), .big_endian(be_q), .a(ca_q), .b(cb_q), .pair(cmp_val)
  );
  casp_pack #(.DW(DW)) u_pack_new (
    .size(sz_q), .big_endian(be_q), .a(na_q), .b(nb_q), .pair(new_val)
  );

  assign old_val  = sz_q ? {bank_q[1], bank_q[0]}
                         : {{DW{1'b0}}, (hi_w ? bank_q[1] : bank_q[0])};
  assign match    = (old_val == cmp_val);
  assign do_write = (state_q == ST_CMP) && !fault_any && match;

  casp_unpack #(.DW(DW)) u_unpack (
    .size(sz_q), .big_endian(be_q), .pair(old_val), .a(old_a), .b(old_b)
  );

  assign ext_go = ext_en_i && !busy_q;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic unit_sel, unit_en;
    assign unit_sel = sz_q || (hi_w == 1'(g));
    assign unit_en  = unit_sel &&
                      (((state_q == ST_CHECK) && !fault_any) || do_write);

    assign bank_en[g]   = busy_q ? unit_en : (ext_go && (ext_addr_i[0] == 1'(g)));
    assign bank_we[g]   = busy_q ? do_write : ext_we_i;
    assign bank_addr[g] = busy_q ? row_w : ext_addr_i[ADDR_W-4:1];
    assign bank_wd[g]   = busy_q ? (sz_q ? new_val[g*DW +: DW] : new_val[DW-1:0])
                                 : ext_wdata_i;

    casp_bank #(.AW(ROW_AW), .DW(DW)) u_bank (
      .clk(clk), .en(bank_en[g]), .we(bank_we[g]), .addr(bank_addr[g]),
      .wdata(bank_wd[g]), .rdata(bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q           <= ST_IDLE;
      busy_q            <= 1'b0;
      req_ack_o         <= 1'b0;
      rsp_valid_o       <= 1'b0;
      rsp_wb_o          <= 1'b0;
      rsp_swapped_o     <= 1'b0;
      rsp_align_fault_o <= 1'b0;
      rsp_illegal_o     <= 1'b0;
      rsp_old_a_o       <= '0;
      rsp_old_b_o       <= '0;
      excl_clr_o        <= 1'b0;
      sz_q   <= 1'b0;
      be_q   <= 1'b0;
      sp_q   <= 1'b0;
      creg_q <= '0;
      sreg_q <= '0;
      addr_q <= '0;
      ca_q   <= '0;
      cb_q   <= '0;
      na_q   <= '0;
      nb_q   <= '0;
    end else begin
      req_ack_o   <= 1'b0;
      rsp_valid_o <= 1'b0;
      excl_clr_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            sz_q   <= req_size_i;
            be_q   <= req_big_endian_i;
            sp_q   <= req_sp_base_i;
            creg_q <= req_cmp_reg_i;
            sreg_q <= req_swap_reg_i;
            addr_q <= req_addr_i;
            ca_q   <= req_cmp_a_i;
            cb_q   <= req_cmp_b_i;
            na_q   <= req_new_a_i;
            nb_q   <= req_new_b_i;
            req_ack_o <= 1'b1;
            busy_q    <= 1'b1;
            state_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          excl_clr_o <= !fault_any;
          state_q    <= ST_CMP;
        end
        ST_CMP: begin
          rsp_valid_o       <= 1'b1;
          rsp_align_fault_o <= align_flt;
          rsp_illegal_o     <= ill_flt;
          if (fault_any) begin
            rsp_old_a_o   <= ca_q;
            rsp_old_b_o   <= cb_q;
            rsp_wb_o      <= 1'b0;
            rsp_swapped_o <= 1'b0;
          end else begin
            rsp_old_a_o   <= old_a;
            rsp_old_b_o   <= old_b;
            rsp_wb_o      <= 1'b1;
            rsp_swapped_o <= match;
          end
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_rvalid_o <= 1'b0;
      ext_bank_q   <= 1'b0;
    end else begin
      ext_rvalid_o <= ext_go && !ext_we_i;
      if (ext_go) ext_bank_q <= ext_addr_i[0];
    end
  end

  assign ext_rdata_o = ext_bank_q ? bank_q[1] : bank_q[0];
  assign ext_ready_o = !busy_q;
  assign busy_o      = busy_q;

  AST_ACK_TO_RESULT: assert property (@(posedge clk) disable iff (rst)
    req_ack_o |-> ##2 rsp_valid_o) else $error("ack not followed by result"); // R1
  AST_IDLE_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> !busy_o) else $error("busy during result"); // R1
  AST_WRITE_MEANS_SWAP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (|(bank_en & bank_we))) |=> rsp_swapped_o) else $error("write without swap"); // R4
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && fault_any) |-> (bank_en == '0)) else $error("faulted access"); // R10
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && (rsp_align_fault_o || rsp_illegal_o)) |-> (!rsp_wb_o && !rsp_swapped_o))
    else $error("fault with writeback"); // R10
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    excl_clr_o |=> (!excl_clr_o && rsp_valid_o)) else $error("clear pulse shape"); // R11
  AST_EXT_STALL: assert property (@(posedge clk) disable iff (rst)
    req_ack_o |-> !ext_ready_o) else $error("ext port open during operation"); // R12
endmodule

// File: tb/tb_casp_pair_unit.sv
`timescale 1ns/1ps
module tb_casp_pair_unit;
  localparam int ADDR_W = 9;
  localparam int DW     = 64;
  localparam int ROWS   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic req_valid, req_size, req_be, req_sp;
  logic [4:0] req_creg, req_sreg;
  logic [ADDR_W-1:0] req_addr;
  logic [DW-1:0] req_ca, req_cb, req_na, req_nb;
  logic ack, busy, rsp_valid, rsp_wb, rsp_sw, rsp_al, rsp_il, excl;
  logic [DW-1:0] old_a, old_b;
  logic ext_en, ext_we, ext_ready, ext_rvalid;
  logic [ADDR_W-4:0] ext_addr;
  logic [DW-1:0] ext_wdata, ext_rdata;

  casp_pair_unit #(.ADDR_W(ADDR_W), .DW(DW)) dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_size_i(req_size),
    .req_big_endian_i(req_be), .req_sp_base_i(req_sp), .req_cmp_reg_i(req_creg),
    .req_swap_reg_i(req_sreg), .req_addr_i(req_addr), .req_cmp_a_i(req_ca),
    .req_cmp_b_i(req_cb), .req_new_a_i(req_na), .req_new_b_i(req_nb),
    .req_ack_o(ack), .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_wb_o(rsp_wb),
    .rsp_swapped_o(rsp_sw), .rsp_align_fault_o(rsp_al), .rsp_illegal_o(rsp_il),
    .rsp_old_a_o(old_a), .rsp_old_b_o(old_b), .excl_clr_o(excl),
    .ext_en_i(ext_en), .ext_we_i(ext_we), .ext_addr_i(ext_addr),
    .ext_wdata_i(ext_wdata), .ext_ready_o(ext_ready), .ext_rvalid_o(ext_rvalid),
    .ext_rdata_o(ext_rdata)
  );

  typedef struct {
    logic [DW-1:0] a, b;
    logic wb, sw, al, il;
    int cyc;
    string tag;
  } exp_t;

  exp_t sb[$];
  logic [DW-1:0] m0 [ROWS];
  logic [DW-1:0] m1 [ROWS];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected results as they appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) chk("R1 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " R1 result cycle"}, 128'(cyc), 128'(e.cyc));
        chk({e.tag, " R6 old a"}, 128'(old_a), 128'(e.a));
        chk({e.tag, " R6 old b"}, 128'(old_b), 128'(e.b));
        chk({e.tag, " R10 writeback"}, 128'(rsp_wb), 128'(e.wb));
        chk({e.tag, " R4 swapped"}, 128'(rsp_sw), 128'(e.sw));
        chk({e.tag, " R8 align"}, 128'(rsp_al), 128'(e.al));
        chk({e.tag, " R7 illegal"}, 128'(rsp_il), 128'(e.il));
      end
    end
  end

  task automatic ext_write(input logic [5:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    ext_en = 1; ext_we = 1; ext_addr = idx; ext_wdata = d;
    @(posedge clk);
    @(negedge clk);
    ext_en = 0; ext_we = 0;
    if (idx[0]) m1[idx[5:1]] = d; else m0[idx[5:1]] = d;
  endtask

  task automatic ext_check(input logic [5:0] idx, input string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    ext_en = 1; ext_we = 0; ext_addr = idx;
    @(posedge clk);
    @(negedge clk);
    ext_en = 0;
    e = idx[0] ? m1[idx[5:1]] : m0[idx[5:1]];
    chk({tag, " R12 ext rvalid"}, 128'(ext_rvalid), 1);
    chk({tag, " ext data"}, 128'(ext_rdata), 128'(e));
  endtask

  task automatic do_op(input string tag, input bit sz, be, sp,
                       input logic [4:0] cr, sr, input logic [ADDR_W-1:0] ad,
                       input logic [DW-1:0] a, b, na, nb, input bit poke);
    exp_t e;
    logic [127:0] mv, cv, nv;
    bit al, il, flt;
    logic [4:0] r;
    r  = ad[8:4];
    il = cr[0] | sr[0];
    al = sp ? (ad[3:0] != 0) : (sz ? (ad[3:0] != 0) : (ad[2:0] != 0));
    flt = al | il;
    e.al = al; e.il = il; e.tag = tag;
    if (flt) begin
      e.a = a; e.b = b; e.wb = 0; e.sw = 0;
    end else begin
      if (sz) begin
        mv = {m1[r], m0[r]};
        cv = be ? {a, b} : {b, a};
        nv = be ? {na, nb} : {nb, na};
      end else begin
        mv = {64'd0, (ad[3] ? m1[r] : m0[r])};
        cv = be ? {64'd0, a[31:0], b[31:0]} : {64'd0, b[31:0], a[31:0]};
        nv = be ? {64'd0, na[31:0], nb[31:0]} : {64'd0, nb[31:0], na[31:0]};
      end
      e.wb = 1;
      e.sw = (mv == cv);
      if (e.sw) begin
        if (sz) begin m1[r] = nv[127:64]; m0[r] = nv[63:0]; end
        else if (ad[3]) m1[r] = nv[63:0];
        else m0[r] = nv[63:0];
      end
      if (sz) begin
        e.a = be ? mv[127:64] : mv[63:0];
        e.b = be ? mv[63:0] : mv[127:64];
      end else begin
        e.a = be ? {32'd0, mv[63:32]} : {32'd0, mv[31:0]};
        e.b = be ? {32'd0, mv[31:0]} : {32'd0, mv[63:32]};
      end
    end
    @(negedge clk);
    req_valid = 1; req_size = sz; req_be = be; req_sp = sp; req_creg = cr;
    req_sreg = sr; req_addr = ad; req_ca = a; req_cb = b; req_na = na; req_nb = nb;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    e.cyc = cyc + 2;
    sb.push_back(e);
    chk({tag, " R1 ack"}, 128'(ack), 1);
    chk({tag, " R1 busy"}, 128'(busy), 1);
    chk({tag, " R12 ready low"}, 128'(ext_ready), 0);
    if (poke) begin
      ext_en = 1; ext_we = 1; ext_addr = {ad[8:4], ad[3]}; ext_wdata = 64'hDEAD_BEEF_0BAD_F00D;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R11 clear pulse"}, 128'(excl), 128'(!flt));
    chk({tag, " R1 no early result"}, 128'(rsp_valid), 0);
    @(posedge clk);
    @(negedge clk);
    ext_en = 0; ext_we = 0;
  endtask

  initial begin
    req_valid = 0; req_size = 0; req_be = 0; req_sp = 0; req_creg = 0; req_sreg = 0;
    req_addr = 0; req_ca = 0; req_cb = 0; req_na = 0; req_nb = 0;
    ext_en = 0; ext_we = 0; ext_addr = 0; ext_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("reset busy", 128'(busy), 0);
    chk("reset result", 128'(rsp_valid), 0);
    chk("reset ack", 128'(ack), 0);
    chk("reset clear", 128'(excl), 0);
    chk("R12 reset ready", 128'(ext_ready), 1);

    for (int i = 0; i < 12; i++)
      ext_write(6'(i), {32'h1000_0000 + 32'(i), 32'hA5A5_0000 + 32'(i * 3)});
    ext_check(6'd5, "R12 readback");

    // R2 size 1 little-endian: compare {b,a}
    do_op("R2 le match", 1, 0, 0, 2, 4, 9'h010, m0[1], m1[1], 64'h1111, 64'h2222, 0);
    ext_check(6'd2, "R4 le low"); ext_check(6'd3, "R4 le high");
    // R2 size 1 big-endian: compare {a,b}
    do_op("R2 be match", 1, 1, 0, 6, 8, 9'h020, m1[2], m0[2], 64'h3333, 64'h4444, 0);
    ext_check(6'd4, "R4 be low"); ext_check(6'd5, "R4 be high");
    do_op("R5 s1 miss", 1, 1, 0, 0, 2, 9'h030, m0[3], m1[3], 64'h5, 64'h6, 0);
    ext_check(6'd6, "R5 unchanged");
    // R3 size 0, junk in upper halves
    do_op("R3 le match", 0, 0, 0, 10, 12, 9'h008,
          {32'hFFFF_FFFF, m1[0][31:0]}, {32'hEEEE_EEEE, m1[0][63:32]},
          64'h7777_7777_ABCD_0001, 64'h8888_8888_ABCD_0002, 0);
    ext_check(6'd1, "R3 le write");
    do_op("R3 be match", 0, 1, 0, 14, 16, 9'h040,
          {32'h0, m0[4][63:32]}, {32'h0, m0[4][31:0]}, 64'h0000_0000_CAFE_0001, 64'h0000_0000_CAFE_0002, 0);
    ext_check(6'd8, "R3 be write");
    do_op("R5 s0 miss", 0, 0, 0, 0, 0, 9'h048, 64'h1, 64'h2, 64'h3, 64'h4, 0);
    ext_check(6'd9, "R5 s0 unchanged");
    // faults
    do_op("R7 odd cmp", 1, 0, 0, 3, 4, 9'h050, m0[5], m1[5], 64'h9, 64'h9, 0);
    do_op("R7 odd swap", 0, 0, 0, 2, 7, 9'h050, m0[5], m1[5], 64'h9, 64'h9, 0);
    do_op("R8 s0 misalign", 0, 1, 0, 2, 4, 9'h05C, 64'h1, 64'h2, 64'h9, 64'h9, 0);
    do_op("R8 s1 misalign", 1, 1, 0, 2, 4, 9'h058, m1[5], m0[5], 64'h9, 64'h9, 0);
    do_op("R9 sp 8-byte", 0, 0, 1, 2, 4, 9'h058, {32'h0, m1[5][31:0]}, {32'h0, m1[5][63:32]}, 64'h9, 64'h9, 0);
    ext_check(6'd10, "R10 no write low"); ext_check(6'd11, "R10 no write high");
    do_op("R9 sp aligned", 1, 0, 1, 2, 4, 9'h050, m0[5], m1[5], 64'hAA, 64'hBB, 0);
    ext_check(6'd10, "R9 sp write");
    // R12 competing write while busy is discarded
    do_op("R12 poke", 1, 0, 0, 0, 2, 9'h000, m0[0], m1[0], 64'hC0, 64'hC1, 1);
    ext_check(6'd0, "R12 poke low"); ext_check(6'd1, "R12 poke high");

    repeat (4) @(negedge clk);
    chk("R1 all results seen", 128'(sb.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule